// File: doc/BRIEF.md
# Four-Channel Power-of-Two Period PWM Timer

This block generates four pulse-width-modulated outputs from one shared time base. A 31-bit counter advances once per clock while counting is enabled. Its value is shifted right by a programmable amount before it reaches four fixed 16-bit comparators. The shift sets the period as a power of two of the clock, and each channel's compare value sets its duty cycle. Every output is active-low. Channel i is driven low while the shifted count is below compare register i, so a compare value of zero keeps the output high for the whole period. The largest compare value, 0xFFFF, still leaves one high step in each period.

Software reaches the block through a word-addressed read/write port. The port gives access to a configuration word, live readback of the raw and the shifted counter, and the four compare registers. The configuration holds two enables: continuous counting, and a single period that disarms itself when the period ends. It also holds an option that ends the period early when the shifted count meets channel 0's compare value, which gives periods that are not powers of two. A compare write takes effect on the next cycle, with no shadow copy. Several further configuration bits are only stored.

Top module: `pwm_timer4`

## Requirements
- R1: After reset, every register reads zero, counting is stopped and all four outputs are high.
- R2: The word addresses are: configuration at 0, raw counter at 2, shifted counter at 4, and compare i at 8+i. Configuration bits [3:0], 8, 9, 10, 12, 13, 16, 24 and 28 are writable and read back; all other configuration bits read 0. A compare register keeps the low 16 bits of the write data. Unmapped addresses read 0.
- R3: The raw counter advances by one per clock while configuration bit 12 or bit 13 is set. When both bits are clear it holds its value.
- R4: The shifted counter reads bits [scale+15:scale] of the raw counter, where scale is configuration bits [3:0].
- R5: With bit 9 clear, the raw counter returns to 0 after 2^(16+scale) counting cycles.
- R6: Output i is low exactly while counting is enabled and the shifted count is below compare i. Otherwise it is high, so a compare value of 0 never drives the output low.
- R7: With compare 0xFFFF, the output is high during the last shifted step of the period, so the duty cycle never reaches 100%.
- R8: With bit 9 set, the counter returns to 0 on the cycle after the shifted count equals compare 0 with the low scale bits all ones. The period is then (compare0+1)·2^scale cycles.
- R9: Bit 13 clears itself at the end of the period. If bit 12 is clear, the counter then rests at 0.
- R10: A compare write affects the output on the next cycle, in the middle of a running period.
- R11: Bits 8, 10, 16, 24 and 28 change neither the counting nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pwm_n | output | 4 | Active-low PWM outputs, one per channel |

## Verification
Each output is tried with a range of compare values: zero, small values, and the maximum 0xFFFF. These values separate a correct less-than test from an off-by-one comparison, and the maximum shows that one high step always remains. The period is tried in three forms: the full power-of-two wrap at scale 0, a non-zero scale, and the early end from the zero-compare option at two scales. Together these separate the shift from the end-of-period detection. Further runs cover single-period mode, a compare change in the middle of a period, a stop in the middle of a run, and the stored-only bits set. These runs distinguish the enables from each other and show that the stored-only bits are inert.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int DATA_W = 32;

    // word addresses
    localparam int WA_CFG  = 0;
    localparam int WA_RAW  = 2;
    localparam int WA_SCL  = 4;
    localparam int WA_CMP0 = 8;

    // configuration bit positions that drive behaviour
    localparam int BIT_ZCMP   = 9;
    localparam int BIT_ALWAYS = 12;
    localparam int BIT_ONCE   = 13;

    // all stored configuration bits
    localparam logic [DATA_W-1:0] CFG_WMASK = 32'h1101_370F;
endpackage

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CMP_W = 16
) (
    input  logic             run,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    output logic             out_n
);
    always_comb begin
        out_n = 1'b1;
        if (run && (scaled < cmp)) begin
            out_n = 1'b0;
        end
    end
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    parameter int CNT_W   = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               zcmp,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CMP_W-1:0]   cmp0,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CMP_W-1:0]   scaled,
    output logic               wrap
);
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] win_mask;
    logic [CNT_W-1:0] low_mask;
    logic             full_end;
    logic             zero_end;

    always_comb begin
        scaled   = CMP_W'(cnt_q >> scale);
        win_mask = CNT_W'(((CNT_W+1)'(1) << (CMP_W + int'(scale))) - (CNT_W+1)'(1));
        low_mask = CNT_W'((CNT_W'(1) << scale) - CNT_W'(1));
        full_end = ((cnt_q & win_mask) == win_mask);
        zero_end = (scaled == cmp0) && ((cnt_q & low_mask) == low_mask);
        wrap     = zcmp ? zero_end : full_end;

        cnt_d = cnt_q;
        if (run) begin
            cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    parameter int CNT_W   = 31,
    parameter int AW      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       once_done,
    input  logic [CNT_W-1:0]           cnt_raw,
    input  logic [CMP_W-1:0]           cnt_scl,
    output logic                       en_always,
    output logic                       en_once,
    output logic                       zcmp,
    output logic [SCALE_W-1:0]         scale,
    output logic                       cfg_wr,
    output logic [NCH-1:0][CMP_W-1:0]  cmp_q
);
    typedef struct packed {
        logic [DATA_W-1:0]         cfg;
        logic [NCH-1:0][CMP_W-1:0] cmp;
    } regs_t;

    regs_t s_q, s_d;

    always_comb begin
        cfg_wr = bus_wr && (int'(bus_addr) == WA_CFG);
        s_d    = s_q;
        if (once_done) begin
            s_d.cfg[BIT_ONCE] = 1'b0;
        end
        if (cfg_wr) begin
            s_d.cfg = bus_wdata & CFG_WMASK;
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_wr && (int'(bus_addr) == WA_CMP0 + i)) begin
                s_d.cmp[i] = bus_wdata[CMP_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == WA_CFG) begin
            bus_rdata = s_q.cfg;
        end
        if (int'(bus_addr) == WA_RAW) begin
            bus_rdata = DATA_W'(cnt_raw);
        end
        if (int'(bus_addr) == WA_SCL) begin
            bus_rdata = DATA_W'(cnt_scl);
        end
        for (int i = 0; i < NCH; i++) begin
            if (int'(bus_addr) == WA_CMP0 + i) begin
                bus_rdata = DATA_W'(s_q.cmp[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_always = s_q.cfg[BIT_ALWAYS];
    assign en_once   = s_q.cfg[BIT_ONCE];
    assign zcmp      = s_q.cfg[BIT_ZCMP];
    assign scale     = s_q.cfg[SCALE_W-1:0];
    assign cmp_q     = s_q.cmp;
endmodule

// File: rtl/pwm_timer4.sv
module pwm_timer4
    import pwm_timer_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    parameter int AW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_n
);
    localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

    logic                      en_always;
    logic                      en_once;
    logic                      zcmp;
    logic [SCALE_W-1:0]        scale;
    logic                      cfg_wr;
    logic [NCH-1:0][CMP_W-1:0] cmp_q;
    logic [CNT_W-1:0]          cnt_q;
    logic [CMP_W-1:0]          scaled;
    logic                      wrap;
    logic                      run;
    logic                      once_done;

    assign run       = en_always | en_once;
    assign once_done = run & wrap & en_once;

    pwm_regs #(
        .NCH(NCH), .CMP_W(CMP_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W), .AW(AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .once_done(once_done), .cnt_raw(cnt_q), .cnt_scl(scaled),
        .en_always(en_always), .en_once(en_once), .zcmp(zcmp), .scale(scale),
        .cfg_wr(cfg_wr), .cmp_q(cmp_q)
    );

    pwm_count #(
        .CMP_W(CMP_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .zcmp(zcmp), .scale(scale),
        .cmp0(cmp_q[0]), .cnt_q(cnt_q), .scaled(scaled), .wrap(wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_chan #(.CMP_W(CMP_W)) u_chan (
            .run(run), .scaled(scaled), .cmp(cmp_q[g]), .out_n(pwm_n[g])
        );
    end
endmodule

// File: rtl/pwm_timer4_chk.sv
module pwm_timer4_chk #(
    parameter int NCH   = 4,
    parameter int CMP_W = 16,
    parameter int CNT_W = 31
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      run,
    input logic                      en_once,
    input logic                      zcmp,
    input logic                      cfg_wr,
    input logic                      wrap,
    input logic [CNT_W-1:0]          cnt,
    input logic [NCH-1:0][CMP_W-1:0] cmp,
    input logic [NCH-1:0]            pwm_n
);
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |-> (&pwm_n)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (cnt == $past(cnt))); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (run && wrap) |=> (cnt == '0)); // R5
    AST_ONCE_DISARM: assert property (@(posedge clk) disable iff (!rst_n) (run && wrap && en_once && !cfg_wr) |=> !en_once); // R9
    AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n) (wrap && !zcmp) |-> (&pwm_n)); // R7

    for (genvar g = 0; g < NCH; g++) begin : g_zero
        AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (cmp[g] == '0) |-> pwm_n[g]); // R6
    end
endmodule

bind pwm_timer4 pwm_timer4_chk #(
    .NCH(NCH), .CMP_W(CMP_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .en_once(en_once), .zcmp(zcmp),
    .cfg_wr(cfg_wr), .wrap(wrap), .cnt(cnt_q), .cmp(cmp_q), .pwm_n(pwm_n)
);

// File: tb/tb_pwm_timer4.sv
`timescale 1ns/1ps
module tb_pwm_timer4;
    localparam int NCH = 4;
    localparam int AW  = 4;
    localparam logic [31:0] ALWAYS = 32'h1000;
    localparam logic [31:0] ONCE   = 32'h2000;
    localparam logic [31:0] ZCMP   = 32'h0200;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] pwm_n;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwm_timer4 dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_n(pwm_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // starts and ends at a falling edge; the write lands on the edge between
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = AW'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(0, v); chk("R1 cfg", v, 0);
        rd(2, v); chk("R1 raw", v, 0);
        rd(4, v); chk("R1 scaled", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(8 + i, v); chk("R1 cmp", v, 0);
        end
        chk("R1 outputs", 32'(pwm_n), 32'hF);
        repeat (3) tick();
        rd(2, v); chk("R3 hold after reset", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        wr(0, 32'hFFFF_CFFF);
        rd(0, v); chk("R2 cfg mask", v, 32'h1101_070F);
        wr(9, 32'hABCD_1234);
        rd(9, v); chk("R2 cmp width", v, 32'h0000_1234);
        rd(3, v); chk("R2 unmapped", v, 0);
        tick();
        rd(2, v); chk("R3 no enable no count", v, 0);
        chk("R6 idle when stopped", 32'(pwm_n), 32'hF);
    endtask

    task automatic t_full();
        logic [31:0] v;
        do_reset();
        wr(8, 32'hFFFF);
        wr(9, 32'h1);
        wr(0, ALWAYS);
        chk("R6 ch0 low at 0", 32'(pwm_n[0]), 0);
        chk("R6 ch1 low at 0", 32'(pwm_n[1]), 0);
        chk("R6 ch2 cmp zero high", 32'(pwm_n[2]), 1);
        tick();
        chk("R6 ch1 high at 1", 32'(pwm_n[1]), 1);
        repeat (65533) tick();
        rd(2, v); chk("R5 raw 65534", v, 65534);
        chk("R6 ch0 low at 65534", 32'(pwm_n[0]), 0);
        tick();
        chk("R7 ch0 high at last step", 32'(pwm_n[0]), 1);
        tick();
        rd(2, v); chk("R5 wrap to zero", v, 0);
        chk("R5 ch0 low after wrap", 32'(pwm_n[0]), 0);
    endtask

    task automatic t_scale();
        logic [31:0] v;
        do_reset();
        wr(10, 2);
        wr(0, ALWAYS | 32'h3);
        for (int k = 0; k <= 40; k++) begin
            if (k == 15) chk("R6 scaled ch2 low", 32'(pwm_n[2]), 0);
            if (k == 16) chk("R6 scaled ch2 high", 32'(pwm_n[2]), 1);
            if (k == 20) begin
                rd(4, v); chk("R4 scaled at 20", v, 2);
                rd(2, v); chk("R4 raw at 20", v, 20);
            end
            if (k == 40) begin
                rd(4, v); chk("R4 scaled at 40", v, 5);
            end
            tick();
        end
    endtask

    task automatic t_zcmp();
        logic [31:0] v;
        do_reset();
        wr(8, 4);
        wr(9, 2);
        wr(0, ALWAYS | ZCMP);
        for (int k = 0; k < 12; k++) begin
            rd(2, v); chk("R8 raw period 5", v, 32'(k % 5));
            chk("R8 ch0 duty", 32'(pwm_n[0]), (k % 5 < 4) ? 0 : 1);
            chk("R8 ch1 duty", 32'(pwm_n[1]), (k % 5 < 2) ? 0 : 1);
            tick();
        end
        do_reset();
        wr(8, 2);
        wr(0, ALWAYS | ZCMP | 32'h1);
        for (int k = 0; k < 14; k++) begin
            rd(2, v); chk("R8 raw period 6 at scale 1", v, 32'(k % 6));
            tick();
        end
    endtask

    task automatic t_once();
        logic [31:0] v;
        do_reset();
        wr(8, 3);
        wr(0, ONCE | ZCMP);
        for (int k = 0; k < 9; k++) begin
            rd(2, v); chk("R9 one-shot count", v, (k < 4) ? 32'(k) : 0);
            chk("R9 one-shot ch0", 32'(pwm_n[0]), (k < 3) ? 0 : 1);
            tick();
        end
        rd(0, v); chk("R9 enable disarmed", v, ZCMP);
    endtask

    task automatic t_live();
        logic [31:0] v;
        do_reset();
        wr(0, ALWAYS);
        repeat (5) tick();
        chk("R10 ch1 high before write", 32'(pwm_n[1]), 1);
        wr(9, 100);
        chk("R10 ch1 low next cycle", 32'(pwm_n[1]), 0);
        wr(9, 3);
        chk("R10 ch1 high after lowering", 32'(pwm_n[1]), 1);
        rd(2, v); chk("R10 raw keeps running", v, 7);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        do_reset();
        wr(8, 500);
        wr(0, ALWAYS);
        repeat (10) tick();
        chk("R6 ch0 low while running", 32'(pwm_n[0]), 0);
        wr(0, 0);
        rd(2, v); chk("R3 last step before stop", v, 11);
        chk("R6 idle after stop", 32'(pwm_n), 32'hF);
        repeat (4) tick();
        rd(2, v); chk("R3 holds when stopped", v, 11);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        do_reset();
        wr(9, 3);
        wr(0, 32'h1101_1500);
        for (int k = 0; k < 6; k++) begin
            rd(2, v); chk("R11 count unaffected", v, 32'(k));
            chk("R11 ch1 unaffected", 32'(pwm_n[1]), (k < 3) ? 0 : 1);
            tick();
        end
        rd(0, v); chk("R11 bits stored", v, 32'h1101_1500);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_full();
        t_scale();
        t_zcmp();
        t_once();
        t_live();
        t_stop();
        t_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule